// File: doc/BRIEF.md
# Crypto Engine Enable Lockdown Controller

This block is the control point that decides whether an on-chip decryption engine and its paired authentication engine may run, and whether encrypted configuration data may be streamed into the programmable logic. Software programs it through a single write port: an address, a data word and a write strobe. A combinational read port returns a read-only status word. The cipher, the hash and the data mover sit outside the block. They only see the enable and gate outputs produced here.

The engine enable is stored as a redundant multi-bit field that reads all ones after power-on reset. The only legal way to turn the engines off is one write that clears every bit of the field at once. That disable is one-way: no later write can bring the engines back, and only a power-on reset restores them. A write that leaves the field in any pattern other than all ones or all zeros while the engines are on is treated as tampering. It raises a permanent lockdown. Lockdown silences the engines and the data gate and freezes the control register.

Three mode bits select the streaming path, partial reconfiguration and a quarter-rate throttle. The throttle is needed because the decryptor takes one byte per cycle. Encrypted transfers are permitted only when the engines are live, lockdown is clear, the programmable logic reports ready, and all three mode bits are set.

Top module: `crypt_gate_ctl`

## Requirements
- R1: After power-on reset (rst_n low), dec_en and auth_en are 1, lockdown is 0, stream_sel, recfg_sel and qrate_sel are 0, and xfer_ok is 0.
- R2: A write to the control address (wr_addr == 0) whose enable field wr_data[2:0] is 3'b000, made while the engines are on and lockdown is clear, turns dec_en and auth_en off from the next cycle. It does not raise lockdown.
- R3: Once the engines are off, no write turns them back on, including writes of 3'b111 to the enable field. Only rst_n restores them.
- R4: A control write with enable field 3'b111 while the engines are on leaves the enables unchanged and does not raise lockdown.
- R5: A control write whose enable field is neither 3'b000 nor 3'b111, made while the engines are on, raises lockdown from the next cycle. The mode bits carried by that same write are discarded.
- R6: Lockdown stays set until rst_n. While it is set, dec_en, auth_en and xfer_ok are 0, and control writes change no mode bit.
- R7: A control write that is accepted (not locked, not a violation) loads stream_sel from wr_data[3], recfg_sel from wr_data[4] and qrate_sel from wr_data[5]. Writes to any other address change nothing.
- R8: xfer_ok is 1 exactly when the engines are on, lockdown is clear, pl_ready is 1, and stream_sel, recfg_sel and qrate_sel are all 1. It follows pl_ready in the same cycle.
- R9: rd_status bit 0 mirrors pl_ready, bit 1 is 1 when the engines are on and lockdown is clear, and bit 2 is the lockdown flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; control register at CTRL_ADDR |
| wr_data | input | EN_W+3 | Write data: enable field low bits, then stream, reconfiguration, throttle |
| pl_ready | input | 1 | Programmable logic powered and ready for encrypted data |
| rd_status | output | 3 | Status: {lockdown, engines live, pl_ready} |
| dec_en | output | 1 | Decryption engine enable |
| auth_en | output | 1 | Authentication engine enable |
| stream_sel | output | 1 | Streaming path select |
| recfg_sel | output | 1 | Partial reconfiguration select |
| qrate_sel | output | 1 | Quarter-rate throttle select |
| lockdown | output | 1 | Security lockdown flag |
| xfer_ok | output | 1 | Encrypted transfer permitted |

## Verification
Two things can happen in one write: the enable field can be judged and the mode bits loaded. The sharpest collisions are a violating pattern carrying mode bits of 3'b111, where the modes must not land and xfer_ok must stay low, and a legal all-zero disable carrying full modes, where the modes do land but xfer_ok still stays low. The bench provokes both directly and again through random writes whose field is drawn from all-zero, all-ones and arbitrary patterns. Every cycle it compares all outputs against a reference model that decides violation before it applies the modes.

// File: rtl/crypt_gate_pkg.sv
package crypt_gate_pkg;

  // Outcome of a control write as seen by the enable field.
  typedef enum logic [1:0] {
    WR_KEEP    = 2'd0,
    WR_DISABLE = 2'd1,
    WR_VIOLATE = 2'd2,
    WR_IGNORE  = 2'd3
  } en_wr_e;

  // Width-independent classification: caller reduces the field to flags.
  function automatic en_wr_e classify_en_write(input logic engines_on,
                                               input logic field_zero,
                                               input logic field_ones);
    if (!engines_on)      return WR_IGNORE;
    else if (field_zero)  return WR_DISABLE;
    else if (field_ones)  return WR_KEEP;
    else                  return WR_VIOLATE;
  endfunction

  // Transfer permission rule.
  function automatic logic transfer_permit(input logic live,
                                           input logic ready,
                                           input logic [2:0] modes);
    return live & ready & (&modes);
  endfunction

endpackage

// File: rtl/cgc_enable_guard.sv
module cgc_enable_guard
  import crypt_gate_pkg::*;
#(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [EN_W-1:0] wr_field,
  output logic            en_on,
  output logic            locked,
  output logic            violate_evt,
  output logic            disable_evt,
  output logic            accept_mode
);

  logic [EN_W-1:0] en_q;
  logic            lock_q;
  en_wr_e          cls;

  assign en_on  = (en_q == {EN_W{1'b1}});
  assign locked = lock_q;

  always_comb begin
    cls         = classify_en_write(en_on,
                                    (wr_field == '0),
                                    (wr_field == {EN_W{1'b1}}));
    violate_evt = wr_hit & ~lock_q & (cls == WR_VIOLATE);
    disable_evt = wr_hit & ~lock_q & (cls == WR_DISABLE);
    accept_mode = wr_hit & ~lock_q & (cls != WR_VIOLATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= {EN_W{1'b1}};
      lock_q <= 1'b0;
    end else begin
      if (violate_evt) lock_q <= 1'b1;
      if (disable_evt) en_q   <= '0;
    end
  end

endmodule

// File: rtl/cgc_mode_regs.sv
module cgc_mode_regs #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (load)  mode_q <= wr_mode;
  end

endmodule

// File: rtl/cgc_xfer_gate.sv
module cgc_xfer_gate
  import crypt_gate_pkg::*;
(
  input  logic       en_on,
  input  logic       locked,
  input  logic       pl_ready,
  input  logic [2:0] modes,
  output logic       live,
  output logic       dec_en,
  output logic       auth_en,
  output logic       xfer_ok,
  output logic [2:0] status
);

  always_comb begin
    live    = en_on & ~locked;
    dec_en  = live;
    auth_en = live;
    xfer_ok = transfer_permit(live, pl_ready, modes);
    status  = {locked, live, pl_ready};
  end

endmodule

// File: rtl/crypt_gate_ctl.sv
module crypt_gate_ctl #(
  parameter int                EN_W      = 3,
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  localparam int               MODE_W    = 3,
  localparam int               WR_W      = EN_W + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              pl_ready,
  output logic [2:0]        rd_status,
  output logic              dec_en,
  output logic              auth_en,
  output logic              stream_sel,
  output logic              recfg_sel,
  output logic              qrate_sel,
  output logic              lockdown,
  output logic              xfer_ok
);

  localparam int MODE_LSB = EN_W;

  // Named internal events, visible to the bound checker.
  logic              wr_hit;
  logic              en_on;
  logic              violate_evt;
  logic              disable_evt;
  logic              accept_mode;
  logic              live;
  logic [MODE_W-1:0] mode_q;

  assign wr_hit = wr_en & (wr_addr == CTRL_ADDR);

  cgc_enable_guard #(.EN_W(EN_W)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (wr_hit),
    .wr_field    (wr_data[EN_W-1:0]),
    .en_on       (en_on),
    .locked      (lockdown),
    .violate_evt (violate_evt),
    .disable_evt (disable_evt),
    .accept_mode (accept_mode)
  );

  cgc_mode_regs #(.MODE_W(MODE_W)) u_modes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_mode),
    .wr_mode (wr_data[MODE_LSB +: MODE_W]),
    .mode_q  (mode_q)
  );

  assign stream_sel = mode_q[0];
  assign recfg_sel  = mode_q[1];
  assign qrate_sel  = mode_q[2];

  cgc_xfer_gate u_gate (
    .en_on    (en_on),
    .locked   (lockdown),
    .pl_ready (pl_ready),
    .modes    (mode_q),
    .live     (live),
    .dec_en   (dec_en),
    .auth_en  (auth_en),
    .xfer_ok  (xfer_ok),
    .status   (rd_status)
  );

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_hit,
  input logic violate_evt,
  input logic disable_evt,
  input logic en_on,
  input logic lockdown,
  input logic dec_en,
  input logic auth_en,
  input logic xfer_ok,
  input logic pl_ready,
  input logic stream_sel,
  input logic recfg_sel,
  input logic qrate_sel
);

  AST_ENG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en == auth_en);                                               // R2

  AST_DISABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    disable_evt |=> !dec_en && !lockdown);                            // R2

  AST_NO_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_on |=> !en_on);                                               // R3

  AST_VIOLATE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    violate_evt |=> lockdown);                                        // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown);                                           // R6

  AST_LOCK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |-> !dec_en && !auth_en && !xfer_ok);                    // R6

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (lockdown && wr_hit) |=> $stable({stream_sel, recfg_sel, qrate_sel})); // R6

  AST_XFER_PREREQ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> pl_ready && stream_sel && recfg_sel && qrate_sel && dec_en); // R8

endmodule

bind crypt_gate_ctl cgc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_hit      (wr_hit),
  .violate_evt (violate_evt),
  .disable_evt (disable_evt),
  .en_on       (en_on),
  .lockdown    (lockdown),
  .dec_en      (dec_en),
  .auth_en     (auth_en),
  .xfer_ok     (xfer_ok),
  .pl_ready    (pl_ready),
  .stream_sel  (stream_sel),
  .recfg_sel   (recfg_sel),
  .qrate_sel   (qrate_sel)
);

// File: tb/crypt_gate_ctl_tb.sv
module crypt_gate_ctl_tb;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       pl_ready = 1'b0;
  logic [2:0] rd_status;
  logic       dec_en, auth_en, stream_sel, recfg_sel, qrate_sel, lockdown, xfer_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  bit       m_on;
  bit       m_lock;
  bit [2:0] m_mode;

  always #(PERIOD/2) clk = ~clk;

  crypt_gate_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pl_ready(pl_ready), .rd_status(rd_status),
    .dec_en(dec_en), .auth_en(auth_en), .stream_sel(stream_sel),
    .recfg_sel(recfg_sel), .qrate_sel(qrate_sel), .lockdown(lockdown),
    .xfer_ok(xfer_ok)
  );

  function automatic bit exp_live();
    return m_on && !m_lock;
  endfunction

  function automatic bit exp_xfer(input bit rdy);
    return exp_live() && rdy && (m_mode == 3'b111);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 dec_en", {7'b0, dec_en}, {7'b0, exp_live()});
    chk("R2 auth_en", {7'b0, auth_en}, {7'b0, exp_live()});
    chk("R6 lockdown", {7'b0, lockdown}, {7'b0, m_lock});
    chk("R7 modes", {5'b0, qrate_sel, recfg_sel, stream_sel}, {5'b0, m_mode});
    chk("R8 xfer_ok", {7'b0, xfer_ok}, {7'b0, exp_xfer(pl_ready)});
    chk("R9 status", {5'b0, rd_status}, {5'b0, m_lock, exp_live(), pl_ready});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    m_on = 1; m_lock = 0; m_mode = '0;
    rst_n = 1'b1;
    #1;
    chk("R1 enables", {6'b0, dec_en, auth_en}, 8'h03);
    chk("R1 lockdown", {7'b0, lockdown}, 8'h00);
    chk("R1 modes", {5'b0, qrate_sel, recfg_sel, stream_sel}, 8'h00);
    chk("R1 xfer_ok", {7'b0, xfer_ok}, 8'h00);
  endtask

  // One cycle: drive at negedge, model at posedge, compare after it.
  task automatic step(input bit we, input logic [1:0] a, input logic [5:0] d, input bit rdy);
    bit viol;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; pl_ready = rdy;
    @(posedge clk);
    if (we && a == 2'd0 && !m_lock) begin
      viol = m_on && d[2:0] != 3'b000 && d[2:0] != 3'b111;
      if (viol) m_lock = 1;
      else begin
        if (m_on && d[2:0] == 3'b000) m_on = 0;
        m_mode = d[5:3];
      end
    end
    #(PERIOD/4);
    check_all();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    do_reset();

    // R4: all-ones rewrite is harmless; modes load (R7)
    step(1, 2'd0, {3'b111, 3'b111}, 1);
    chk("R4 still on", {7'b0, dec_en}, 8'h01);
    chk("R8 xfer permitted", {7'b0, xfer_ok}, 8'h01);
    // R8: drop ready, same cycle
    @(negedge clk); pl_ready = 0; #1;
    chk("R8 ready low", {7'b0, xfer_ok}, 8'h00);
    // R7: other address ignored
    step(1, 2'd1, {3'b000, 3'b000}, 1);
    chk("R7 other addr", {5'b0, qrate_sel, recfg_sel, stream_sel}, 8'h07);
    // R2: disable together with full modes
    step(1, 2'd0, {3'b111, 3'b000}, 1);
    chk("R2 disabled", {6'b0, dec_en, auth_en}, 8'h00);
    chk("R2 no lock", {7'b0, lockdown}, 8'h00);
    chk("R8 xfer off when disabled", {7'b0, xfer_ok}, 8'h00);
    // R3: no re-enable
    step(1, 2'd0, {3'b111, 3'b111}, 1);
    chk("R3 stays off", {7'b0, dec_en}, 8'h00);
    chk("R3 no lock", {7'b0, lockdown}, 8'h00);

    // R5: violation with full modes
    do_reset();
    step(1, 2'd0, {3'b111, 3'b101}, 1);
    chk("R5 lockdown", {7'b0, lockdown}, 8'h01);
    chk("R5 modes discarded", {5'b0, qrate_sel, recfg_sel, stream_sel}, 8'h00);
    // R6: writes ignored while locked
    step(1, 2'd0, {3'b111, 3'b111}, 1);
    chk("R6 modes frozen", {5'b0, qrate_sel, recfg_sel, stream_sel}, 8'h00);
    chk("R6 silenced", {5'b0, dec_en, auth_en, xfer_ok}, 8'h00);
    chk("R9 status locked", {5'b0, rd_status}, 8'h05);

    // Random phase
    do_reset();
    for (int i = 0; i < 800; i++) begin
      bit we, rdy;
      logic [1:0] a;
      logic [2:0] f, md;
      int r;
      if (i % 60 == 59) do_reset();
      we  = ($urandom % 10) < 7;
      a   = (($urandom % 10) < 8) ? 2'd0 : 2'(1 + $urandom % 3);
      r   = $urandom % 4;
      f   = (r == 0) ? 3'b000 : (r == 2) ? 3'($urandom) : 3'b111;
      md  = (($urandom % 2) == 0) ? 3'b111 : 3'($urandom);
      rdy = ($urandom % 4) != 0;
      step(we, a, {md, f}, rdy);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule